// File: doc/BRIEF.md
# Descriptor Chain DMA Sequencer

This block is the control engine of one copy channel. Software places a linked list of descriptors in memory. Each descriptor names a byte count, a source, a destination and the address of the next descriptor. The block fetches each descriptor and moves the bytes through a local buffer. After every descriptor it posts a completion word to a programmed address, then follows the link. One word-wide request port carries all four kinds of memory traffic: descriptor reads, source reads, destination writes and completion writes.

Software drives the block with three command strobes. Start begins a walk at the programmed chain address. Append covers the case where software has linked new work onto the tail of a list the block has already finished: only the link field of the last descriptor is read again. Reset abandons the walk. Two latencies set by parameters shape the timing. One is a wait before each descriptor fetch, and the other is a pause after each completion write. Two counters report the bytes moved and the descriptors copied.

Top module: `chain_dma_seq`

## Requirements
- R1: A memory request keeps `mem_req`, `mem_wr` and `mem_addr` steady until `mem_done` is high at a clock edge. Each request moves one 64-bit word, at an address that is a multiple of 8.
- R2: While idle, a start strobe sets `xfer_status` to 0 and raises `busy` on the next cycle. The first descriptor read, at `chain_addr`, appears LAT_BEFORE+1 cycles after the strobe's edge. A start strobe while busy is ignored.
- R3: A reset strobe makes the block idle on the next cycle, with `xfer_status` = 3, and drops any pending append. A hardware reset gives the same state with both counters at zero.
- R4: A descriptor is four words, read in the order +0, +8, +16, +24. The word at +0 holds the control word in bits 63:32 and the byte length in bits 31:0. The word at +8 is the source, +16 is the destination and +24 is the next pointer.
- R5: A copy reads ceil(len/8) words from the source in rising address order, then writes the same data in the same order to the destination. A length of zero moves no data.
- R6: After the last destination write, the block writes the word {descriptor address[63:6], 6'b0} | 1 to `cpl_addr`. It then waits LAT_AFTER cycles before continuing, so `busy` falls LAT_AFTER+1 cycles after the write is acknowledged when the chain ends there.
- R7: A descriptor with control bit 0 set (null) moves no data and leaves the counters unchanged. It writes the previous completion word again (zero after reset) to `cpl_addr`.
- R8: A non-null descriptor that has any control bit other than bit 1 set, or whose length exceeds BUF_WORDS*8 bytes, stops the walk. `xfer_status` becomes 2 and no completion word is written.
- R9: After a completion, a nonzero next pointer starts a fetch at that address. With a zero next pointer, a pending append reads the next pointer of the last descriptor again; with no append pending, the block goes idle.
- R10: An append strobe while idle reads only the word at last descriptor + 24. A zero value returns the block to idle, and a nonzero value starts a fetch there. An append strobe while busy is recorded as pending.
- R11: Each copied descriptor adds its length to `bytes_copied` and one to `copies_done`.
- R12: `busy` is high in every state except idle, and no memory request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start strobe |
| cmd_append | input | 1 | Append strobe |
| cmd_reset | input | 1 | Abandon strobe |
| chain_addr | input | ADDR_W | First descriptor address |
| cpl_addr | input | ADDR_W | Completion word address |
| busy | output | 1 | Channel not idle |
| xfer_status | output | 2 | 0 running/done, 2 fault, 3 halted |
| mem_req | output | 1 | Memory request valid |
| mem_wr | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 64 | Write data |
| mem_done | input | 1 | Request acknowledged; read data valid |
| mem_rdata | input | 64 | Read data |
| bytes_copied | output | CNT_W | Total bytes copied |
| copies_done | output | CNT_W | Descriptors copied |

## Verification
A command strobe is taken at one edge. Status and `busy` then change on the next cycle, and the first descriptor read comes LAT_BEFORE+1 cycles after the start edge. When a chain ends, `busy` falls LAT_AFTER+1 cycles after the completion write is acknowledged. The bench drives and samples only at falling edges, and counts rising edges to check these two distances exactly. Every memory access is compared, when the bench acknowledges it, against a queue of expected accesses. A behavioural walker fills that queue from the bench's own memory image, so ordering, addresses and write data are checked one access at a time.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_NEXT,
        ST_RD,
        ST_WR,
        ST_CPL
    } seq_state_e;

    localparam logic [1:0] XS_RUN   = 2'd0;
    localparam logic [1:0] XS_FAULT = 2'd2;
    localparam logic [1:0] XS_HALT  = 2'd3;

    localparam int WORD_W     = 64;
    localparam int LEN_W      = 32;
    localparam int NEXT_OFS   = 24;
    localparam int CPL_SHIFT  = 6;
endpackage

// File: rtl/cdma_copy_buf.sv
module cdma_copy_buf #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    assign rd_data = store[rd_idx];
endmodule

// File: rtl/cdma_stats.sv
module cdma_stats #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic [LEN_W-1:0] add_len,
    output logic [CNT_W-1:0] bytes_total,
    output logic [CNT_W-1:0] copy_total
);
    logic [CNT_W-1:0] bytes_d, bytes_q, copy_d, copy_q;

    always_comb begin
        bytes_d = bytes_q;
        copy_d  = copy_q;
        if (bump) begin
            bytes_d = bytes_q + CNT_W'(add_len);
            copy_d  = copy_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_q <= '0;
            copy_q  <= '0;
        end else begin
            bytes_q <= bytes_d;
            copy_q  <= copy_d;
        end
    end

    assign bytes_total = bytes_q;
    assign copy_total  = copy_q;
endmodule

// File: rtl/chain_dma_seq.sv
module chain_dma_seq
    import chain_dma_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int BUF_WORDS  = 16,
    parameter int LAT_BEFORE = 2,
    parameter int LAT_AFTER  = 2,
    parameter int LAT_W      = 8,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_append,
    input  logic              cmd_reset,
    input  logic [ADDR_W-1:0] chain_addr,
    input  logic [ADDR_W-1:0] cpl_addr,
    output logic              busy,
    output logic [1:0]        xfer_status,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_done,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  bytes_copied,
    output logic [CNT_W-1:0]  copies_done
);
    localparam int IDXW = $clog2(BUF_WORDS + 1);
    localparam int BAW  = $clog2(BUF_WORDS);

    typedef struct packed {
        seq_state_e        st;
        logic [IDXW-1:0]   idx;
        logic [LAT_W-1:0]  cnt;
        logic              post;
        logic              refresh;
        logic [1:0]        xfer;
        logic [ADDR_W-1:0] fetch;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] nxt;
        logic [LEN_W-1:0]  dlen;
        logic [31:0]       dctl;
        logic [WORD_W-1:0] cword;
    } seq_t;

    seq_t s_d, s_q;

    logic [LEN_W:0]      words_w;
    logic                too_big, ctl_bad;
    logic [IDXW-1:0]     nwords;
    logic [ADDR_W-1:0]   word_off;
    logic                buf_we, stat_bump;
    logic [WORD_W-1:0]   buf_rdata;

    assign words_w  = ({1'b0, s_q.dlen} + (LEN_W+1)'(7)) >> 3;
    assign too_big  = words_w > (LEN_W+1)'(BUF_WORDS);
    assign nwords   = words_w[IDXW-1:0];
    assign ctl_bad  = |(s_q.dctl & ~32'h2);
    assign word_off = ADDR_W'(s_q.idx) << 3;

    always_comb begin
        s_d       = s_q;
        mem_req   = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        buf_we    = 1'b0;
        stat_bump = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_start) begin
                    s_d.xfer  = XS_RUN;
                    s_d.fetch = chain_addr;
                    s_d.idx   = '0;
                    s_d.cnt   = LAT_W'(LAT_BEFORE);
                    s_d.st    = ST_DESC;
                end else if (cmd_append) begin
                    s_d.st = ST_NEXT;
                end
            end
            ST_DESC: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - LAT_W'(1);
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = s_q.fetch + word_off;
                    if (mem_done) begin
                        s_d.idx = s_q.idx + IDXW'(1);
                        unique case (s_q.idx[1:0])
                            2'd0: begin
                                s_d.dlen = mem_rdata[LEN_W-1:0];
                                s_d.dctl = mem_rdata[63:32];
                            end
                            2'd1: s_d.src = mem_rdata[ADDR_W-1:0];
                            2'd2: s_d.dst = mem_rdata[ADDR_W-1:0];
                            default: begin
                                s_d.nxt  = mem_rdata[ADDR_W-1:0];
                                s_d.last = s_q.fetch;
                                s_d.idx  = '0;
                                s_d.post = 1'b0;
                                if (s_q.dctl[0]) begin
                                    s_d.st = ST_CPL;
                                end else if (ctl_bad || too_big) begin
                                    s_d.xfer = XS_FAULT;
                                    s_d.st   = ST_IDLE;
                                end else begin
                                    s_d.st = ST_RD;
                                end
                            end
                        endcase
                    end
                end
            end
            ST_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = s_q.last + ADDR_W'(NEXT_OFS);
                if (mem_done) begin
                    s_d.nxt = mem_rdata[ADDR_W-1:0];
                    if (mem_rdata[ADDR_W-1:0] == '0) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.fetch = mem_rdata[ADDR_W-1:0];
                        s_d.idx   = '0;
                        s_d.cnt   = LAT_W'(LAT_BEFORE);
                        s_d.st    = ST_DESC;
                    end
                end
            end
            ST_RD: begin
                if (s_q.idx == nwords) begin
                    s_d.idx = '0;
                    s_d.st  = ST_WR;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = s_q.src + word_off;
                    if (mem_done) begin
                        buf_we  = 1'b1;
                        s_d.idx = s_q.idx + IDXW'(1);
                    end
                end
            end
            ST_WR: begin
                if (s_q.idx == nwords) begin
                    s_d.cword = WORD_W'({s_q.last[ADDR_W-1:CPL_SHIFT], CPL_SHIFT'(0)})
                              | WORD_W'(1);
                    stat_bump = 1'b1;
                    s_d.post  = 1'b0;
                    s_d.st    = ST_CPL;
                end else begin
                    mem_req   = 1'b1;
                    mem_wr    = 1'b1;
                    mem_addr  = s_q.dst + word_off;
                    mem_wdata = buf_rdata;
                    if (mem_done) begin
                        s_d.idx = s_q.idx + IDXW'(1);
                    end
                end
            end
            ST_CPL: begin
                if (!s_q.post) begin
                    mem_req   = 1'b1;
                    mem_wr    = 1'b1;
                    mem_addr  = cpl_addr;
                    mem_wdata = s_q.cword;
                    if (mem_done) begin
                        s_d.post = 1'b1;
                        s_d.cnt  = LAT_W'(LAT_AFTER);
                    end
                end else if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - LAT_W'(1);
                end else begin
                    s_d.post = 1'b0;
                    if (s_q.nxt != '0) begin
                        s_d.fetch = s_q.nxt;
                        s_d.idx   = '0;
                        s_d.cnt   = LAT_W'(LAT_BEFORE);
                        s_d.st    = ST_DESC;
                    end else if (s_q.refresh) begin
                        s_d.refresh = 1'b0;
                        s_d.st      = ST_NEXT;
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (cmd_append && (s_q.st != ST_IDLE)) begin
            s_d.refresh = 1'b1;
        end
        if (cmd_reset) begin
            s_d.st      = ST_IDLE;
            s_d.xfer    = XS_HALT;
            s_d.refresh = 1'b0;
            s_d.post    = 1'b0;
            s_d.cnt     = '0;
            s_d.idx     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.xfer <= XS_HALT;
        end else begin
            s_q <= s_d;
        end
    end

    cdma_copy_buf #(
        .DEPTH (BUF_WORDS),
        .WIDTH (WORD_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_idx  (s_q.idx[BAW-1:0]),
        .wr_data (mem_rdata),
        .rd_idx  (s_q.idx[BAW-1:0]),
        .rd_data (buf_rdata)
    );

    cdma_stats #(
        .CNT_W (CNT_W),
        .LEN_W (LEN_W)
    ) u_stats (
        .clk         (clk),
        .rst_n       (rst_n),
        .bump        (stat_bump),
        .add_len     (s_q.dlen),
        .bytes_total (bytes_copied),
        .copy_total  (copies_done)
    );

    assign busy        = (s_q.st != ST_IDLE);
    assign xfer_status = s_q.xfer;
endmodule

// File: rtl/cdma_seq_checks.sv
module cdma_seq_checks #(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic              cmd_reset,
    input logic              busy,
    input logic [1:0]        xfer_status,
    input logic              mem_req,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_done,
    input logic [CNT_W-1:0]  copies_done
);
    // R3: abandon strobe lands the channel in idle with halted status
    a_r3_abandon_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (!busy && xfer_status == 2'd3));

    // R2: start from idle raises busy with running status
    a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start && !cmd_reset) |=> (busy && xfer_status == 2'd0));

    // R1: request held steady until acknowledged
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done && !cmd_reset)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_wr)));

    // R1: word-aligned request addresses
    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    // R12: idle channel issues no traffic
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R11: copy counter advances by at most one per cycle
    a_r11_copy_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((copies_done == $past(copies_done)) ||
                  (copies_done == $past(copies_done) + CNT_W'(1))));
endmodule

bind chain_dma_seq cdma_seq_checks #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .cmd_reset   (cmd_reset),
    .busy        (busy),
    .xfer_status (xfer_status),
    .mem_req     (mem_req),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .mem_done    (mem_done),
    .copies_done (copies_done)
);

// File: tb/test_chain_dma_seq.sv
`timescale 1ns/1ps
module test_chain_dma_seq;
    localparam int LB = 3;
    localparam int LA = 2;
    localparam int BW = 16;
    localparam int MEM_LAT = 1;
    localparam logic [63:0] CPL = 64'h0000_0000_0000_7F00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0, cmd_append = 1'b0, cmd_reset = 1'b0;
    logic [63:0] chain_addr = '0;
    logic [63:0] cpl_addr = CPL;
    logic        busy;
    logic [1:0]  xfer_status;
    logic        mem_req, mem_wr;
    logic [63:0] mem_addr, mem_wdata;
    logic        mem_done = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [31:0] bytes_copied, copies_done;

    always #4 clk = ~clk;

    chain_dma_seq #(
        .ADDR_W(64), .BUF_WORDS(BW), .LAT_BEFORE(LB), .LAT_AFTER(LA),
        .LAT_W(8), .CNT_W(32)
    ) i_chain_dma_seq (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_append(cmd_append),
        .cmd_reset(cmd_reset), .chain_addr(chain_addr), .cpl_addr(cpl_addr),
        .busy(busy), .xfer_status(xfer_status), .mem_req(mem_req), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_done(mem_done),
        .mem_rdata(mem_rdata), .bytes_copied(bytes_copied), .copies_done(copies_done)
    );

    typedef struct {
        bit          wr;
        logic [63:0] addr;
        logic [63:0] data;
        string       tag;
    } xact_t;

    logic [63:0] mem [logic [63:0]];
    xact_t       expq [$];
    int          checks = 0, errors = 0, cyc = 0, wc = 0, last_cpl_cyc = 0;
    bit          cmp_en = 1'b1;

    logic [63:0] m_lastcw = '0;
    longint      m_bytes = 0, m_copies = 0;
    int          m_status = 3;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic push(input bit wr, input logic [63:0] a, input logic [63:0] d,
                        input string tag);
        xact_t e;
        e.wr = wr; e.addr = a; e.data = d; e.tag = tag;
        expq.push_back(e);
    endtask

    // behavioural walker: expected access list from the memory image
    task automatic walk(input logic [63:0] start);
        logic [63:0] a, w0, src, dst, nx;
        longint      len, n;
        logic [31:0] ctl;
        bit          fin;
        a = start;
        fin = 1'b0;
        while (!fin) begin
            for (int i = 0; i < 4; i++) push(1'b0, a + 64'(8 * i), '0, "R4");
            w0 = rd(a); ctl = w0[63:32]; len = longint'(w0[31:0]);
            src = rd(a + 8); dst = rd(a + 16); nx = rd(a + 24);
            if (ctl[0]) begin
                push(1'b1, CPL, m_lastcw, "R7");
            end else if (((ctl & ~32'h2) != 0) || (len > BW * 8)) begin
                m_status = 2;
                return;
            end else begin
                n = (len + 7) / 8;
                for (longint i = 0; i < n; i++) push(1'b0, src + 64'(8 * i), '0, "R5");
                for (longint i = 0; i < n; i++)
                    push(1'b1, dst + 64'(8 * i), rd(src + 64'(8 * i)), "R5");
                m_lastcw = {a[63:6], 6'b0} | 64'd1;
                push(1'b1, CPL, m_lastcw, "R6");
                m_bytes += len;
                m_copies++;
            end
            if (nx == 0) fin = 1'b1;
            else a = nx;
        end
    endtask

    task automatic mk_desc(input logic [63:0] a, input logic [31:0] ctl,
                           input logic [31:0] len, input logic [63:0] src,
                           input logic [63:0] dst, input logic [63:0] nx);
        mem[a] = {ctl, len}; mem[a + 8] = src; mem[a + 16] = dst; mem[a + 24] = nx;
        for (int i = 0; i < BW; i++) mem[src + 64'(8 * i)] = {a[31:0], 32'(i) ^ 32'hA5A5_0000};
    endtask

    // memory responder and access comparison
    always @(negedge clk) begin
        xact_t e;
        if (mem_done) begin
            mem_done = 1'b0;
            wc = 0;
        end else if (mem_req) begin
            if (wc < MEM_LAT) wc++;
            else begin
                if (cmp_en) begin
                    if (expq.size() == 0) chk(1'b0, "R1", "unexpected access", mem_addr, '0);
                    else begin
                        e = expq.pop_front();
                        chk(e.wr == mem_wr && e.addr == mem_addr, e.tag, "access addr",
                            mem_addr, e.addr);
                        if (e.wr && mem_wr) chk(e.data == mem_wdata, e.tag, "write data",
                                                mem_wdata, e.data);
                    end
                end
                if (mem_wr) begin
                    mem[mem_addr] = mem_wdata;
                    if (mem_addr == CPL) last_cpl_cyc = cyc;
                end else mem_rdata = rd(mem_addr);
                mem_done = 1'b1;
            end
        end else wc = 0;
        if (rst_n && !busy) chk(!mem_req, "R12", "request while idle", 64'(mem_req), 0);
    end

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) cmd_start = 1'b1;
        else if (which == 1) cmd_append = 1'b1;
        else cmd_reset = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; cmd_append = 1'b0; cmd_reset = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(!busy, tag, "channel did not settle", 64'(busy), 0);
    endtask

    task automatic end_checks(input string tag);
        chk(expq.size() == 0, tag, "accesses left", 64'(expq.size()), 0);
        chk(64'(xfer_status) == 64'(m_status), tag, "status", 64'(xfer_status), 64'(m_status));
        chk(64'(bytes_copied) == 64'(m_bytes), "R11", "bytes", 64'(bytes_copied), 64'(m_bytes));
        chk(64'(copies_done) == 64'(m_copies), "R11", "copies", 64'(copies_done), 64'(m_copies));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 64'(cyc), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s;
        // reset state: R3
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R3", "busy after reset", 64'(busy), 0);
        chk(xfer_status == 2'd3, "R3", "status after reset", 64'(xfer_status), 3);
        chk(copies_done == 0 && bytes_copied == 0, "R3", "counters after reset",
            64'(copies_done), 0);

        // two-descriptor chain, start latency, ignored start: R2 R4 R5 R6 R9
        mk_desc(64'h1000, 32'h2, 32'd20, 64'h8000, 64'h9000, 64'h1040);
        mk_desc(64'h1040, 32'h0, 32'd16, 64'h8100, 64'h9100, 64'h0);
        m_status = 0;
        walk(64'h1000);
        chain_addr = 64'h1000;
        @(negedge clk);
        s = cyc;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(busy && xfer_status == 2'd0, "R2", "running after start", 64'(xfer_status), 0);
        while (!mem_req) @(negedge clk);
        chk(cyc - s == LB + 1, "R2", "first fetch delay", 64'(cyc - s), 64'(LB + 1));
        chain_addr = 64'h5_5550_0000;
        pulse(0);
        wait_idle("R9");
        chk(cyc - last_cpl_cyc == LA + 2, "R6", "post-completion pause",
            64'(cyc - last_cpl_cyc), 64'(LA + 2));
        chk(rd(CPL) == 64'h1041, "R6", "completion word", rd(CPL), 64'h1041);
        chk(rd(64'h9010) == rd(64'h8010), "R5", "third copied word", rd(64'h9010), rd(64'h8010));
        end_checks("R9");

        // append with empty link: R10
        push(1'b0, 64'h1058, '0, "R10");
        pulse(1);
        wait_idle("R10");
        end_checks("R10");

        // append with new work, zero length and null descriptors: R10 R7 R5
        mk_desc(64'h1080, 32'h2, 32'd0, 64'h8200, 64'h9200, 64'h10C0);
        mk_desc(64'h10C0, 32'h1, 32'd40, 64'h8300, 64'h9300, 64'h1100);
        mk_desc(64'h1100, 32'h0, 32'd8, 64'h8400, 64'h9400, 64'h0);
        mem[64'h1058] = 64'h1080;
        push(1'b0, 64'h1058, '0, "R10");
        walk(64'h1080);
        pulse(1);
        wait_idle("R7");
        chk(!mem.exists(64'h9300), "R7", "null descriptor moved data", rd(64'h9300), 0);
        end_checks("R7");

        // fault cases: bad control bit, oversize length: R8
        mk_desc(64'h1140, 32'h4, 32'd8, 64'h8500, 64'h9500, 64'h1180);
        walk(64'h1140);
        chain_addr = 64'h1140;
        pulse(0);
        wait_idle("R8");
        end_checks("R8");
        mk_desc(64'h1180, 32'h0, 32'(BW * 8 + 1), 64'h8600, 64'h9600, 64'h0);
        walk(64'h1180);
        chain_addr = 64'h1180;
        pulse(0);
        wait_idle("R8");
        chk(rd(CPL) == 64'h1101, "R8", "no completion on fault", rd(CPL), 64'h1101);
        end_checks("R8");

        // append while busy becomes a pending re-read: R9 R10
        mk_desc(64'h11C0, 32'h0, 32'd24, 64'h8700, 64'h9700, 64'h0);
        mk_desc(64'h1200, 32'h0, 32'd8, 64'h8800, 64'h9800, 64'h0);
        mem[64'h11D8] = 64'h0;
        m_status = 0;
        walk(64'h11C0);
        mem[64'h11D8] = 64'h1200;
        push(1'b0, 64'h11D8, '0, "R9");
        walk(64'h1200);
        mem[64'h11D8] = 64'h0;
        chain_addr = 64'h11C0;
        pulse(0);
        while (!(mem_req && mem_wr)) @(negedge clk);
        mem[64'h11D8] = 64'h1200;
        pulse(1);
        wait_idle("R9");
        end_checks("R9");

        // abandon mid-walk: R3
        mk_desc(64'h1240, 32'h0, 32'd64, 64'h8900, 64'h9900, 64'h0);
        chain_addr = 64'h1240;
        cmp_en = 1'b0;
        pulse(0);
        repeat (10) @(negedge clk);
        cmd_reset = 1'b1;
        @(negedge clk);
        cmd_reset = 1'b0;
        chk(!busy, "R3", "busy after abandon", 64'(busy), 0);
        chk(xfer_status == 2'd3, "R3", "status after abandon", 64'(xfer_status), 3);
        repeat (6) @(negedge clk);
        chk(!busy && !mem_req, "R3", "quiet after abandon", 64'(mem_req), 0);
        expq.delete();
        cmp_en = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule